// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core which older in-flight store a newly fetched load or store must wait for. It learns from ordering violations: each time a load is caught having read memory ahead of an older store to the same address, the load and that store are put into a common group (a "store set"). From then on, the load waits for the youngest in-flight store of its group. The block also makes stores of one group execute one after the other.

Two direct-mapped tables hold the learned state. The first maps the low bits of an instruction PC to a set number. The second maps a set number to the store-queue tag of the youngest fetched but not yet issued store of that set. The front end presents each load or store at fetch and gets a dependence (valid flag plus store-queue tag) back in the same cycle. The issue stage reports each issuing store. The violation logic reports the PCs of the offending load and store.

Top module: `storeSetPredictor`

## Requirements
- R1: After reset, and in the cycle after `clearAll` is asserted, every table entry is invalid, so no fetched load or store receives a dependence until new violations are learned.
- R2: The PC table is indexed by the low 6 bits of the PC, so two PCs equal in those bits share an entry. The store table is indexed by the 4-bit set number.
- R3: A violation in which neither the load PC nor the store PC has a set gives both a fresh set number from a wrapping allocation counter that starts at 0. That set is distinct from the sets handed out before.
- R4: A violation in which exactly one of the two PCs has a set places the other PC into that set.
- R5: A violation in which both PCs have sets writes the smaller of the two set numbers into both PC entries.
- R6: A fetched store whose PC maps to a valid set becomes that set's youngest store: its `fetchTag` is recorded for that set.
- R7: A fetched load whose set holds a youngest store returns `depValid`=1 and `depTag` equal to that store's tag in the same cycle. In all other cases it returns `depValid`=0.
- R8: A fetched store in a valid set returns the tag of the set's previous youngest store as its dependence, in the same way as a load.
- R9: An issuing store empties its set's youngest-store entry only when the recorded tag equals `issueTag`. A stale tag leaves the entry unchanged.
- R10: When a store of a set is fetched in the same cycle that a store of the same set issues, the newly fetched store's tag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearAll | input | 1 | Invalidate both tables and restart set allocation |
| fetchValid | input | 1 | A load or store is presented at fetch |
| fetchIsStore | input | 1 | 1 = store, 0 = load |
| fetchPc | input | 16 | PC of the fetched instruction |
| fetchTag | input | 5 | Store-queue tag of a fetched store |
| depValid | output | 1 | The fetched instruction must wait for a store |
| depTag | output | 5 | Store-queue tag to wait for |
| issueValid | input | 1 | A store issues |
| issuePc | input | 16 | PC of the issuing store |
| issueTag | input | 5 | Store-queue tag of the issuing store |
| violValid | input | 1 | An ordering violation is reported |
| violLoadPc | input | 16 | PC of the violating load |
| violStorePc | input | 16 | PC of the violating store |

## Verification
The bench builds sets in all three violation cases and merges sets in both directions: once with the load holding the smaller number and once with the store holding it. A design that keeps the load's number or the larger number would send one of the later loads to the wrong store. It issues a store with a stale tag and then with the current one. An unconditional release would drop a younger store, and a missing release would leave a load waiting forever. It fetches and issues into one set in the same cycle, which catches a release that overrides the new store. After a global clear it learns a fresh store and checks that loads still see nothing, which exposes a clear that empties only the store table.

// File: rtl/sspPkg.sv
package sspPkg;
  localparam int unsigned PcW     = 16;
  localparam int unsigned IdxW    = 6;
  localparam int unsigned SetW    = 4;
  localparam int unsigned TagW    = 5;
  localparam int unsigned Entries = 1 << IdxW;
  localparam int unsigned Sets    = 1 << SetW;

  typedef struct packed {
    logic            clear;
    logic            ssitWr;
    logic [SetW-1:0] ssitId;
    logic            lfstSet;
    logic [SetW-1:0] setId;
    logic            lfstRel;
    logic [SetW-1:0] relId;
  } sspStrobes_t;
endpackage

// File: rtl/sspDatapath.sv
module sspDatapath
  import sspPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobes_t       strb,
  input  logic [IdxW-1:0]   fetchIdx,
  input  logic [TagW-1:0]   fetchTag,
  input  logic [IdxW-1:0]   issueIdx,
  input  logic [TagW-1:0]   issueTag,
  input  logic [IdxW-1:0]   ldIdx,
  input  logic [IdxW-1:0]   stIdx,
  output logic              fetchHit,
  output logic [SetW-1:0]   fetchId,
  output logic              fetchLive,
  output logic [TagW-1:0]   fetchLastTag,
  output logic              issHit,
  output logic [SetW-1:0]   issId,
  output logic              issTagMatch,
  output logic              ldHit,
  output logic [SetW-1:0]   ldId,
  output logic              stHit,
  output logic [SetW-1:0]   stId
);
  logic [Entries-1:0] ssitValid;
  logic [SetW-1:0]    ssitId [Entries];
  logic [Sets-1:0]    lfstValid;
  logic [TagW-1:0]    lfstTag [Sets];

  // Table reads, all combinational on the state before the edge
  always_comb begin
    fetchHit     = ssitValid[fetchIdx];
    fetchId      = ssitId[fetchIdx];
    fetchLive    = fetchHit && lfstValid[fetchId];
    fetchLastTag = lfstTag[fetchId];
    issHit       = ssitValid[issueIdx];
    issId        = ssitId[issueIdx];
    issTagMatch  = lfstValid[issId] && (lfstTag[issId] == issueTag);
    ldHit        = ssitValid[ldIdx];
    ldId         = ssitId[ldIdx];
    stHit        = ssitValid[stIdx];
    stId         = ssitId[stIdx];
  end

  // PC-indexed set table
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      ssitValid <= '0;
    end else if (strb.ssitWr) begin
      ssitValid[ldIdx] <= 1'b1;
      ssitValid[stIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && !strb.clear && strb.ssitWr) begin
      ssitId[ldIdx] <= strb.ssitId;
      ssitId[stIdx] <= strb.ssitId;
    end
  end

  // Set-indexed youngest-store table
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      lfstValid <= '0;
    end else begin
      if (strb.lfstRel) lfstValid[strb.relId] <= 1'b0;
      if (strb.lfstSet) lfstValid[strb.setId] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && !strb.clear && strb.lfstSet) lfstTag[strb.setId] <= fetchTag;
  end

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (ssitValid == '0) && (lfstValid == '0));

  assert_violation_joins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ssitWr && !strb.clear) |=>
      ssitValid[$past(ldIdx)] && ssitValid[$past(stIdx)] &&
      (ssitId[$past(ldIdx)] == ssitId[$past(stIdx)]));

  assert_store_recorded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lfstSet && !strb.clear) |=>
      lfstValid[$past(strb.setId)] && (lfstTag[$past(strb.setId)] == $past(fetchTag)));

  assert_release_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lfstRel && !strb.clear) |=> !lfstValid[$past(strb.relId)]);
endmodule

// File: rtl/sspControl.sv
module sspControl
  import sspPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            clearAll,
  input  logic            fetchValid,
  input  logic            fetchIsStore,
  input  logic            fetchHit,
  input  logic [SetW-1:0] fetchId,
  input  logic            issueValid,
  input  logic            issHit,
  input  logic [SetW-1:0] issId,
  input  logic            issTagMatch,
  input  logic            violValid,
  input  logic            ldHit,
  input  logic [SetW-1:0] ldId,
  input  logic            stHit,
  input  logic [SetW-1:0] stId,
  output sspStrobes_t     strb
);
  logic [SetW-1:0] allocCnt;
  logic            allocStep;

  always_comb begin
    strb        = '0;
    allocStep   = 1'b0;
    strb.clear  = clearAll;
    strb.ssitWr = violValid && !clearAll;
    unique case ({ldHit, stHit})
      2'b00: begin
        strb.ssitId = allocCnt;
        allocStep   = strb.ssitWr;
      end
      2'b10:   strb.ssitId = ldId;
      2'b01:   strb.ssitId = stId;
      default: strb.ssitId = (ldId < stId) ? ldId : stId;
    endcase
    strb.lfstSet = fetchValid && fetchIsStore && fetchHit && !clearAll;
    strb.setId   = fetchId;
    strb.lfstRel = issueValid && issHit && issTagMatch && !clearAll &&
                   !(strb.lfstSet && (fetchId == issId));
    strb.relId   = issId;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearAll) allocCnt <= '0;
    else if (allocStep)    allocCnt <= allocCnt + 1'b1;
  end

  assert_fresh_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (violValid && !ldHit && !stHit && !clearAll) |=> allocCnt == $past(allocCnt) + 1'b1);

  assert_merge_smaller_R5: assert property (@(posedge clk) disable iff (!rstN)
    (violValid && ldHit && stHit) |->
      (strb.ssitId <= ldId) && (strb.ssitId <= stId) &&
      ((strb.ssitId == ldId) || (strb.ssitId == stId)));

  assert_fetch_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lfstSet && strb.lfstRel) |-> (strb.setId != strb.relId));
endmodule

// File: rtl/storeSetPredictor.sv
module storeSetPredictor
  import sspPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            clearAll,
  input  logic            fetchValid,
  input  logic            fetchIsStore,
  input  logic [PcW-1:0]  fetchPc,
  input  logic [TagW-1:0] fetchTag,
  output logic            depValid,
  output logic [TagW-1:0] depTag,
  input  logic            issueValid,
  input  logic [PcW-1:0]  issuePc,
  input  logic [TagW-1:0] issueTag,
  input  logic            violValid,
  input  logic [PcW-1:0]  violLoadPc,
  input  logic [PcW-1:0]  violStorePc
);
  sspStrobes_t     strb;
  logic            fetchHit, fetchLive, issHit, issTagMatch, ldHit, stHit;
  logic [SetW-1:0] fetchId, issId, ldId, stId;
  logic [TagW-1:0] fetchLastTag;
  logic            unusedPcBits;

  assign unusedPcBits = ^{fetchPc[PcW-1:IdxW], issuePc[PcW-1:IdxW],
                          violLoadPc[PcW-1:IdxW], violStorePc[PcW-1:IdxW]};

  sspDatapath u_data (
    .clk, .rstN, .strb,
    .fetchIdx(fetchPc[IdxW-1:0]), .fetchTag,
    .issueIdx(issuePc[IdxW-1:0]), .issueTag,
    .ldIdx(violLoadPc[IdxW-1:0]), .stIdx(violStorePc[IdxW-1:0]),
    .fetchHit, .fetchId, .fetchLive, .fetchLastTag,
    .issHit, .issId, .issTagMatch,
    .ldHit, .ldId, .stHit, .stId
  );

  sspControl u_ctrl (
    .clk, .rstN, .clearAll,
    .fetchValid, .fetchIsStore, .fetchHit, .fetchId,
    .issueValid, .issHit, .issId, .issTagMatch,
    .violValid, .ldHit, .ldId, .stHit, .stId,
    .strb
  );

  assign depValid = fetchValid && fetchLive;
  assign depTag   = fetchLastTag;

  assert_dep_needs_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    depValid |-> fetchValid);
endmodule

// File: tb/test_storeSetPredictor.sv
module test_storeSetPredictor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearAll = 1'b0;
  logic        fetchValid = 1'b0, fetchIsStore = 1'b0;
  logic [15:0] fetchPc = '0;
  logic [4:0]  fetchTag = '0;
  logic        depValid;
  logic [4:0]  depTag;
  logic        issueValid = 1'b0;
  logic [15:0] issuePc = '0;
  logic [4:0]  issueTag = '0;
  logic        violValid = 1'b0;
  logic [15:0] violLoadPc = '0, violStorePc = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic       expVq [$];
  logic [4:0] expTq [$];
  string      reqQ  [$];

  always #10 clk = ~clk;  // 50 MHz

  storeSetPredictor i_storeSetPredictor (
    .clk, .rstN, .clearAll, .fetchValid, .fetchIsStore, .fetchPc, .fetchTag,
    .depValid, .depTag, .issueValid, .issuePc, .issueTag,
    .violValid, .violLoadPc, .violStorePc
  );

  task automatic idleInputs();
    clearAll = 1'b0; fetchValid = 1'b0; fetchIsStore = 1'b0;
    issueValid = 1'b0; violValid = 1'b0;
  endtask

  task automatic pushExp(input logic v, input logic [4:0] t, input string req);
    expVq.push_back(v); expTq.push_back(t); reqQ.push_back(req);
  endtask

  task automatic doFetch(input logic isSt, input logic [15:0] pc, input logic [4:0] tag,
                         input logic expV, input logic [4:0] expT, input string req);
    @(negedge clk); idleInputs();
    fetchValid = 1'b1; fetchIsStore = isSt; fetchPc = pc; fetchTag = tag;
    pushExp(expV, expT, req);
  endtask

  task automatic doIssue(input logic [15:0] pc, input logic [4:0] tag);
    @(negedge clk); idleInputs();
    issueValid = 1'b1; issuePc = pc; issueTag = tag;
  endtask

  task automatic doViol(input logic [15:0] ld, input logic [15:0] st);
    @(negedge clk); idleInputs();
    violValid = 1'b1; violLoadPc = ld; violStorePc = st;
  endtask

  task automatic doClear();
    @(negedge clk); idleInputs(); clearAll = 1'b1;
  endtask

  // Monitor: compares outputs mid-low-phase of every cycle carrying a fetch
  initial begin
    forever begin
      @(negedge clk); #5;
      if (expVq.size() > 0) begin
        logic v; logic [4:0] t; string r;
        v = expVq.pop_front(); t = expTq.pop_front(); r = reqQ.pop_front();
        checks++;
        if (depValid !== v || (v && depTag !== t)) begin
          fails++;
          $display("FAIL %s: depValid=%0b depTag=%0d expected depValid=%0b depTag=%0d",
                   r, depValid, depTag, v, t);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doFetch(0, 16'h010, 0, 0, 0, "R1 reset state");
    doFetch(1, 16'h020, 3, 0, 0, "R7 no set");
    doViol(16'h010, 16'h020);                         // set 0
    doFetch(0, 16'h010, 0, 0, 0, "R7 empty set");
    doFetch(1, 16'h020, 7, 0, 0, "R8 no prior store");
    doFetch(0, 16'h010, 0, 1, 7, "R6 R7 load waits");
    doFetch(1, 16'h020, 9, 1, 7, "R8 store chain");
    doIssue(16'h020, 7);                              // stale
    doFetch(0, 16'h010, 0, 1, 9, "R9 stale issue kept");
    doIssue(16'h020, 9);
    doFetch(0, 16'h010, 0, 0, 0, "R9 matching issue clears");
    doViol(16'h011, 16'h021);                         // set 1
    doFetch(1, 16'h021, 4, 0, 0, "R3 new set empty");
    doFetch(0, 16'h011, 0, 1, 4, "R3 new set");
    doFetch(0, 16'h010, 0, 0, 0, "R3 distinct set");
    doViol(16'h010, 16'h022);                         // store joins set 0
    doFetch(1, 16'h022, 12, 0, 0, "R4 store joins");
    doFetch(0, 16'h010, 0, 1, 12, "R4 store joins");
    doViol(16'h012, 16'h021);                         // load joins set 1
    doFetch(0, 16'h012, 0, 1, 4, "R4 load joins");
    doViol(16'h010, 16'h021);                         // merge, load holds smaller
    doFetch(1, 16'h021, 15, 1, 12, "R5 merge to load set");
    doFetch(0, 16'h011, 0, 1, 4, "R5 other entries kept");
    doViol(16'h012, 16'h022);                         // merge, store holds smaller
    doFetch(0, 16'h012, 0, 1, 15, "R5 merge to store set");
    @(negedge clk); idleInputs();
    fetchValid = 1'b1; fetchIsStore = 1'b1; fetchPc = 16'h020; fetchTag = 20;
    issueValid = 1'b1; issuePc = 16'h021; issueTag = 15;
    pushExp(1'b1, 5'd15, "R8 store with issue");
    doFetch(0, 16'h010, 0, 1, 20, "R10 fetch wins");
    doFetch(0, 16'h050, 0, 1, 20, "R2 aliased PC");
    doFetch(0, 16'h013, 0, 0, 0, "R2 other index");
    doClear();
    doFetch(0, 16'h010, 0, 0, 0, "R1 after clear");
    doFetch(1, 16'h020, 1, 0, 0, "R1 store after clear");
    doFetch(0, 16'h010, 0, 0, 0, "R1 set table cleared");
    @(negedge clk); idleInputs();
    @(negedge clk); #8;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule